// File: doc/BRIEF.md
# Corner-Turn Transpose Buffer for an 8x8 Bit-Serial Transform

This block sits between the row pass and the column pass of a separable two-dimensional 8x8 transform built from bit-serial arithmetic. It has two independent paths. The sample path takes 8-bit pixel samples, one word per cycle. Each group of eight is turned into eight bit-serial lanes that feed the row pass.

The matrix path receives the row-pass results as eight bit-serial lanes, least significant bit first. Each result is gathered into an 11-bit word, and each set of eight words is written into a 64-entry store as one row. After the eighth row is stored, the block reads the store one column at a time. It emits each column as eight least-significant-bit-first lanes, each sign-extended to a wider serial width for the column pass.

A start pulse opens a new block. A done flag marks the cycle that carries the final bit of the last column.

Top module: `ct_corner_turn`

## Requirements
- R1: When the eighth sample of a group is accepted (`smp_valid` high), `in_valid` is high for the next IN_SER_W (default 11) consecutive cycles, starting the cycle after. In these cycles lane k of `in_bits` carries the k-th accepted sample of the group (k=0 first), least significant bit first. `in_first` is high only in the cycle that carries bit 0.
- R2: With SIGNED_IN=1 (default), samples are two's complement, and every serial bit above bit 7 equals bit 7 of the sample.
- R3: While the block is filling, each cycle with `row_valid` high supplies bit j of the current row on lane k, counting only valid cycles. Cycles with `row_valid` low are skipped. Bit j is the j-th valid cycle (LSB first) of a MID_W-bit (default 11) two's-complement word, and lane k holds column k. Rows fill in order 0 to 7.
- R4: Row lanes presented before the first start, while columns are being read out, or after done, are ignored and leave the stored matrix and the row position unchanged.
- R5: If the last bit of row 7 is presented in cycle t, `col_valid` first rises in cycle t+2.
- R6: Columns come out in order 0 to 7. Each takes OUT_W (default 14) back-to-back cycles, for 112 valid cycles in all. Lane i carries the element at row i of the current column, least significant bit first. `col_first` marks bit 0 of each column.
- R7: Each column word is sign-extended from MID_W bits to OUT_W bits: output bits MID_W..OUT_W-1 repeat bit MID_W-1.
- R8: `done` is high in the cycle that carries the final bit of column 7. It stays high until the next start. `col_valid` is low after that cycle.
- R9: A start pulse restarts the block from any state: a partial row is dropped, row counting restarts at row 0, and any readout stops. In the cycle after the start, `col_valid`, `col_first`, `col_bits` and `done` are all low.
- R10: After reset, `in_valid`, `in_first`, `in_bits`, `col_valid`, `col_first`, `col_bits` and `done` are low, and row lanes are ignored until a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a new block; restarts the matrix path |
| smp_valid | input | 1 | Sample word present this cycle |
| smp_data | input | SMP_W (8) | Input sample, word-serial |
| in_bits | output | N (8) | Serial lanes toward the row pass, one bit per lane |
| in_valid | output | 1 | Input lanes carry a bit |
| in_first | output | 1 | Input lanes carry bit 0 |
| row_valid | input | 1 | Row-pass result lanes carry a bit |
| row_bits | input | N (8) | Row-pass result lanes, LSB first |
| col_bits | output | N (8) | Column lanes toward the column pass, LSB first |
| col_valid | output | 1 | Column lanes carry a bit |
| col_first | output | 1 | Column lanes carry bit 0 |
| done | output | 1 | Final column bit reached; held until start |

## Verification
The sample path is driven with back-to-back groups and with groups whose samples are spaced by idle cycles. The samples include 0x80, 0x7F, 0xFF and zero, so lane ordering, LSB-first ordering and sign fill are each told apart.

The matrix is filled with values that differ in every row and column and that include -1024 and 1023. Any swap of rows against columns, any misplaced bit and any wrong extension therefore shows up in the column stream. Some rows carry idle gaps mid-word, which separates counting valid cycles from counting clock cycles.

Garbage rows are presented before the first start and during readout to expose lanes that are not ignored. Starts are issued in the middle of a readout and in the middle of a partial row to exercise the restart.

// File: rtl/ct_pkg.sv
package ct_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_FILL  = 2'd1,
      PH_DRAIN = 2'd2,
      PH_DONE  = 2'd3
   } ct_phase_e;

endpackage

// File: rtl/ct_sample_lanes.sv
module ct_sample_lanes #(
   parameter int SMP_W     = 8,
   parameter int LANES     = 8,
   parameter int SER_W     = 11,
   parameter bit SIGNED_IN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_valid,
   input  logic [SMP_W-1:0] smp_data,
   output logic [LANES-1:0] lane_bits,
   output logic             lane_valid,
   output logic             lane_first
);

   localparam int CW  = $clog2(LANES);
   localparam int BW  = $clog2(SER_W);
   localparam int EXT = SER_W - SMP_W;

   if (SER_W <= SMP_W) begin : g_bad_ser
      $error("ct_sample_lanes: SER_W must exceed SMP_W");
   end
   if (LANES < 2) begin : g_bad_lanes
      $error("ct_sample_lanes: LANES must be at least 2");
   end

   logic [SMP_W-1:0] gath [LANES];
   logic [CW-1:0]    gcnt;
   logic [SER_W-1:0] shreg [LANES];
   logic [SER_W-1:0] ext_w [LANES];
   logic [BW-1:0]    bcnt;
   logic             busy;
   logic             group_end;
   logic             load;

   assign group_end = (gcnt == CW'(LANES - 1));
   assign load      = smp_valid && group_end;

   // the last word of a group goes straight to the serializer
   for (genvar k = 0; k < LANES; k++) begin : g_ext
      logic [SMP_W-1:0] src;
      if (k == LANES - 1) begin : g_direct
         assign src = smp_data;
      end else begin : g_held
         assign src = gath[k];
      end
      if (SIGNED_IN) begin : g_sign
         assign ext_w[k] = {{EXT{src[SMP_W-1]}}, src};
      end else begin : g_zero
         assign ext_w[k] = {{EXT{1'b0}}, src};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gcnt <= '0;
         bcnt <= '0;
         busy <= 1'b0;
      end else begin
         if (smp_valid) begin
            gcnt <= group_end ? '0 : gcnt + 1'b1;
         end
         if (load) begin
            bcnt <= '0;
            busy <= 1'b1;
         end else if (busy) begin
            bcnt <= bcnt + 1'b1;
            if (bcnt == BW'(SER_W - 1)) begin
               busy <= 1'b0;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (smp_valid) begin
         gath[gcnt] <= smp_data;
      end
      for (int k = 0; k < LANES; k++) begin
         if (load) begin
            shreg[k] <= ext_w[k];
         end else if (busy) begin
            shreg[k] <= shreg[k] >> 1;
         end
      end
   end

   for (genvar k = 0; k < LANES; k++) begin : g_out
      assign lane_bits[k] = busy & shreg[k][0];
   end
   assign lane_valid = busy;
   assign lane_first = busy && (bcnt == '0);

   // R1
   lane_lead_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lane_valid) |-> lane_first);
   // R1
   lane_len_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && bcnt == BW'(SER_W - 1) && !load) |=> !lane_valid);
   // R1
   lane_start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lane_valid) |-> $past(smp_valid));

endmodule

// File: rtl/ct_lane_collect.sv
module ct_lane_collect #(
   parameter int LANES = 8,
   parameter int W     = 11
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clr,
   input  logic                      en,
   input  logic                      lane_valid,
   input  logic [LANES-1:0]          lane_bits,
   output logic                      row_we,
   output logic [LANES-1:0][W-1:0]   row_words
);

   localparam int BW = $clog2(W);

   if (W < 3) begin : g_bad_w
      $error("ct_lane_collect: W must be at least 3");
   end

   logic [W-2:0] part [LANES];
   logic [BW-1:0] cnt;
   logic          take;
   logic          last;

   assign take   = en && lane_valid;
   assign last   = (cnt == BW'(W - 1));
   assign row_we = take && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (take) begin
         cnt <= last ? '0 : cnt + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      for (int k = 0; k < LANES; k++) begin
         if (take) begin
            part[k] <= {lane_bits[k], part[k][W-2:1]};
         end
      end
   end

   for (genvar k = 0; k < LANES; k++) begin : g_word
      assign row_words[k] = {lane_bits[k], part[k]};
   end

   // R3
   row_bitcount_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      row_we |=> (cnt == '0));
   // R4
   row_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !clr) |=> $stable(cnt));

endmodule

// File: rtl/ct_store.sv
module ct_store #(
   parameter int N = 8,
   parameter int W = 11
) (
   input  logic                  clk,
   input  logic                  we,
   input  logic [$clog2(N)-1:0]  wrow,
   input  logic [N-1:0][W-1:0]   wdata,
   input  logic [$clog2(N)-1:0]  rcol,
   output logic [N-1:0][W-1:0]   rdata
);

   localparam int CW    = $clog2(N);
   localparam int AW    = 2 * CW;
   localparam int DEPTH = N * N;

   logic [W-1:0] mem [DEPTH];

   // entry address is row*N + column for both sides
   always_ff @(posedge clk) begin
      if (we) begin
         for (int c = 0; c < N; c++) begin
            mem[{wrow, CW'(c)}] <= wdata[c];
         end
      end
   end

   for (genvar r = 0; r < N; r++) begin : g_rd
      logic [AW-1:0] raddr;
      assign raddr    = {CW'(r), rcol};
      assign rdata[r] = mem[raddr];
   end

endmodule

// File: rtl/ct_col_emit.sv
module ct_col_emit #(
   parameter int N     = 8,
   parameter int W     = 11,
   parameter int OUT_W = 14
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic                  en,
   input  logic [N-1:0][W-1:0]   col_words,
   output logic [$clog2(N)-1:0]  rcol,
   output logic [N-1:0]          lane_bits,
   output logic                  lane_valid,
   output logic                  lane_first,
   output logic                  fin
);

   localparam int CW  = $clog2(N);
   localparam int OB  = $clog2(OUT_W);
   localparam int EXT = OUT_W - W;

   if (OUT_W <= W) begin : g_bad_out
      $error("ct_col_emit: OUT_W must exceed W");
   end

   logic [OB-1:0]    rbit;
   logic [N-1:0]     bits_nx;
   logic             col_end;

   for (genvar r = 0; r < N; r++) begin : g_ext
      logic [OUT_W-1:0] wide;
      assign wide       = {{EXT{col_words[r][W-1]}}, col_words[r]};
      assign bits_nx[r] = wide[rbit];
   end

   assign col_end = (rbit == OB'(OUT_W - 1));
   assign fin     = en && col_end && (rcol == CW'(N - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rcol       <= '0;
         rbit       <= '0;
         lane_bits  <= '0;
         lane_valid <= 1'b0;
         lane_first <= 1'b0;
      end else if (clr) begin
         rcol       <= '0;
         rbit       <= '0;
         lane_bits  <= '0;
         lane_valid <= 1'b0;
         lane_first <= 1'b0;
      end else if (en) begin
         lane_bits  <= bits_nx;
         lane_valid <= 1'b1;
         lane_first <= (rbit == '0);
         if (col_end) begin
            rbit <= '0;
            rcol <= rcol + 1'b1;
         end else begin
            rbit <= rbit + 1'b1;
         end
      end else begin
         lane_bits  <= '0;
         lane_valid <= 1'b0;
         lane_first <= 1'b0;
      end
   end

   // R6
   col_lead_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lane_valid) |-> lane_first);
   // R6
   col_first_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_first && $past(lane_valid)) |-> ($past(rbit) == OB'(OUT_W - 1)) || (rbit == OB'(1)));
   // R8
   col_quiet_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_valid |-> (lane_bits == '0));

endmodule

// File: rtl/ct_corner_turn.sv
module ct_corner_turn #(
   parameter int SMP_W     = 8,
   parameter int N         = 8,
   parameter int MID_W     = 11,
   parameter int IN_SER_W  = 11,
   parameter int OUT_W     = 14,
   parameter bit SIGNED_IN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             smp_valid,
   input  logic [SMP_W-1:0] smp_data,
   output logic [N-1:0]     in_bits,
   output logic             in_valid,
   output logic             in_first,
   input  logic             row_valid,
   input  logic [N-1:0]     row_bits,
   output logic [N-1:0]     col_bits,
   output logic             col_valid,
   output logic             col_first,
   output logic             done
);

   import ct_pkg::*;

   localparam int CW = $clog2(N);

   if (N < 2 || (N & (N - 1)) != 0) begin : g_bad_n
      $error("ct_corner_turn: N must be a power of two, at least 2");
   end
   if (MID_W <= SMP_W) begin : g_bad_mid
      $error("ct_corner_turn: MID_W must exceed SMP_W");
   end

   ct_phase_e              phase;
   logic [CW-1:0]          wrow;
   logic                   fill_en;
   logic                   drain_en;
   logic                   row_we;
   logic [N-1:0][MID_W-1:0] row_words;
   logic [N-1:0][MID_W-1:0] col_words;
   logic [CW-1:0]          rcol;
   logic                   fin;

   assign fill_en  = (phase == PH_FILL)  && !start;
   assign drain_en = (phase == PH_DRAIN) && !start;

   ct_sample_lanes #(
      .SMP_W     (SMP_W),
      .LANES     (N),
      .SER_W     (IN_SER_W),
      .SIGNED_IN (SIGNED_IN)
   ) u_smp (
      .clk        (clk),
      .rst_n      (rst_n),
      .smp_valid  (smp_valid),
      .smp_data   (smp_data),
      .lane_bits  (in_bits),
      .lane_valid (in_valid),
      .lane_first (in_first)
   );

   ct_lane_collect #(
      .LANES (N),
      .W     (MID_W)
   ) u_collect (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (start),
      .en         (fill_en),
      .lane_valid (row_valid),
      .lane_bits  (row_bits),
      .row_we     (row_we),
      .row_words  (row_words)
   );

   ct_store #(
      .N (N),
      .W (MID_W)
   ) u_store (
      .clk   (clk),
      .we    (row_we),
      .wrow  (wrow),
      .wdata (row_words),
      .rcol  (rcol),
      .rdata (col_words)
   );

   ct_col_emit #(
      .N     (N),
      .W     (MID_W),
      .OUT_W (OUT_W)
   ) u_emit (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (start),
      .en         (drain_en),
      .col_words  (col_words),
      .rcol       (rcol),
      .lane_bits  (col_bits),
      .lane_valid (col_valid),
      .lane_first (col_first),
      .fin        (fin)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         wrow  <= '0;
      end else if (start) begin
         phase <= PH_FILL;
         wrow  <= '0;
      end else begin
         unique case (phase)
            PH_FILL: begin
               if (row_we) begin
                  wrow <= wrow + 1'b1;
                  if (wrow == CW'(N - 1)) begin
                     phase <= PH_DRAIN;
                  end
               end
            end
            PH_DRAIN: begin
               if (fin) begin
                  phase <= PH_DONE;
               end
            end
            default: ;
         endcase
      end
   end

   assign done = (phase == PH_DONE);

   // R8
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);
   // R8
   done_on_last_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> col_valid);
   // R8
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(done)) |-> !col_valid);
   // R9
   start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (!done && !col_valid && !col_first && col_bits == '0));
   // R4
   row_pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_FILL && !start) |=> $stable(wrow));

endmodule

// File: tb/tb_ct_corner_turn.sv
module tb_ct_corner_turn;

   localparam int N        = 8;
   localparam int SMP_W    = 8;
   localparam int MID_W    = 11;
   localparam int IN_SER_W = 11;
   localparam int OUT_W    = 14;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic             smp_valid = 1'b0;
   logic [SMP_W-1:0] smp_data = '0;
   logic [N-1:0]     in_bits;
   logic             in_valid;
   logic             in_first;
   logic             row_valid = 1'b0;
   logic [N-1:0]     row_bits = '0;
   logic [N-1:0]     col_bits;
   logic             col_valid;
   logic             col_first;
   logic             done;

   int errors = 0;
   int checks = 0;

   always #2 clk = ~clk;

   ct_corner_turn #(
      .SMP_W (SMP_W), .N (N), .MID_W (MID_W),
      .IN_SER_W (IN_SER_W), .OUT_W (OUT_W), .SIGNED_IN (1'b1)
   ) dut (
      .clk (clk), .rst_n (rst_n), .start (start),
      .smp_valid (smp_valid), .smp_data (smp_data),
      .in_bits (in_bits), .in_valid (in_valid), .in_first (in_first),
      .row_valid (row_valid), .row_bits (row_bits),
      .col_bits (col_bits), .col_valid (col_valid), .col_first (col_first),
      .done (done)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int val(input int p, input int r, input int c);
      if (r == 0 && c == 0) return -1024;
      if (r == N - 1 && c == N - 1) return 1023;
      return ((r * 37 + c * 91 + p * 53 + r * c * 13) % 2048) - 1024;
   endfunction

   // ---------------- behavioural reference ----------------
   int grp [N];
   int ser_w [N];
   int gcnt, sbit;
   bit sbusy;
   int mat [N*N];
   int acc [N];
   int ph;            // 0 idle, 1 fill, 2 drain, 3 done
   int rrow, rbit_in, ccol, cbit;
   bit e_cvalid, e_cfirst;
   int e_cbits;
   int cyc = 0;
   int fill_end = -10;

   always @(posedge clk) begin
      if (!rst_n) begin
         gcnt = 0; sbit = 0; sbusy = 0;
         ph = 0; rrow = 0; rbit_in = 0; ccol = 0; cbit = 0;
         e_cvalid = 0; e_cfirst = 0; e_cbits = 0;
         for (int k = 0; k < N; k++) acc[k] = 0;
      end else begin
         // sample path (R1, R2)
         begin
            bit ld;
            ld = 0;
            if (smp_valid) begin
               grp[gcnt] = $signed(smp_data);
               if (gcnt == N - 1) begin
                  for (int k = 0; k < N; k++) ser_w[k] = grp[k];
                  sbit = 0; sbusy = 1; gcnt = 0; ld = 1;
               end else begin
                  gcnt++;
               end
            end
            if (!ld && sbusy) begin
               if (sbit == IN_SER_W - 1) sbusy = 0;
               else sbit++;
            end
         end
         // matrix path (R3..R9)
         if (start) begin
            ph = 1; rrow = 0; rbit_in = 0; ccol = 0; cbit = 0;
            for (int k = 0; k < N; k++) acc[k] = 0;
            e_cvalid = 0; e_cfirst = 0; e_cbits = 0;
         end else if (ph == 2) begin
            e_cbits = 0;
            for (int i = 0; i < N; i++)
               e_cbits |= ((mat[i*N + ccol] >>> cbit) & 1) << i;
            e_cvalid = 1; e_cfirst = (cbit == 0);
            if (cbit == OUT_W - 1) begin
               cbit = 0;
               if (ccol == N - 1) ph = 3;
               ccol++;
            end else begin
               cbit++;
            end
         end else begin
            e_cvalid = 0; e_cfirst = 0; e_cbits = 0;
            if (ph == 1 && row_valid) begin
               for (int k = 0; k < N; k++) acc[k] |= int'(row_bits[k]) << rbit_in;
               if (rbit_in == MID_W - 1) begin
                  for (int k = 0; k < N; k++) begin
                     mat[rrow*N + k] = (acc[k] >= 1024) ? acc[k] - 2048 : acc[k];
                     acc[k] = 0;
                  end
                  rbit_in = 0;
                  rrow++;
                  if (rrow == N) begin ph = 2; fill_end = cyc; end
               end else begin
                  rbit_in++;
               end
            end
         end
      end
      cyc++;
   end

   // ---------------- per-cycle comparison ----------------
   bit prev_cv = 0;
   bit prev_done = 0;
   int vcount = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         int eb;
         eb = 0;
         if (sbusy)
            for (int k = 0; k < N; k++) eb |= ((ser_w[k] >>> sbit) & 1) << k;
         chk("R1 in_valid", int'(in_valid), int'(sbusy));
         chk("R1 in_first", int'(in_first), int'(sbusy && sbit == 0));
         chk("R1/R2 in_bits", int'(in_bits), eb);
         chk("R6 col_valid", int'(col_valid), int'(e_cvalid));
         chk("R6 col_first", int'(col_first), int'(e_cfirst));
         chk("R6/R7 col_bits", int'(col_bits), e_cbits);
         chk("R8 done", int'(done), int'(ph == 3));
         if (col_valid && !prev_cv) begin
            vcount = 0;
            if (fill_end >= 0) chk("R5 first column latency", cyc - fill_end, 2);
            fill_end = -10;
         end
         if (col_valid) vcount++;
         if (done && !prev_done) chk("R6 total column cycles", vcount, N * OUT_W);
         prev_cv = col_valid;
         prev_done = done;
      end
      if (cyc > 60000) begin
         errors++;
         checks++;
         $display("FAIL watchdog R8 run did not finish actual=%0d expected=%0d", cyc, 60000);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         row_valid = 0; smp_valid = 0; start = 0; row_bits = '0;
      end
   endtask

   task automatic pulse_start();
      @(negedge clk);
      start = 1; row_valid = 0; smp_valid = 0;
      @(negedge clk);
      start = 0;
   endtask

   task automatic send_group(input logic [SMP_W-1:0] s [N], input bit gaps);
      for (int k = 0; k < N; k++) begin
         if (gaps && (k % 3) == 1) begin
            @(negedge clk);
            smp_valid = 0; smp_data = 8'h5A;
         end
         @(negedge clk);
         smp_valid = 1; smp_data = s[k];
      end
      @(negedge clk);
      smp_valid = 0;
   endtask

   // R3: one row, LSB first, optionally with idle cycles mid-word
   task automatic send_row(input int p, input int r, input bit gaps);
      for (int j = 0; j < MID_W; j++) begin
         if (gaps && (j % 4) == 2) begin
            @(negedge clk);
            row_valid = 0; row_bits = 8'hA5;
         end
         @(negedge clk);
         row_valid = 1;
         for (int k = 0; k < N; k++) row_bits[k] = 1'((val(p, r, k) >>> j) & 1);
      end
   endtask

   task automatic fill(input int p, input bit gaps);
      for (int r = 0; r < N; r++) send_row(p, r, gaps && (r == 2 || r == 5));
      idle(1);
   endtask

   task automatic wait_done();
      while (!done) @(negedge clk);
   endtask

   initial begin
      logic [SMP_W-1:0] ga [N];
      logic [SMP_W-1:0] gb [N];
      ga = '{8'h05, 8'hF3, 8'h80, 8'h7F, 8'h00, 8'hFF, 8'h41, 8'hAA};
      gb = '{8'h12, 8'h81, 8'hFE, 8'h01, 8'h7E, 8'hC0, 8'h3C, 8'h99};
      repeat (3) @(negedge clk);
      // R10: reset values
      chk("R10 in_valid", int'(in_valid), 0);
      chk("R10 in_bits", int'(in_bits), 0);
      chk("R10 col_valid", int'(col_valid), 0);
      chk("R10 col_first", int'(col_first), 0);
      chk("R10 col_bits", int'(col_bits), 0);
      chk("R10 done", int'(done), 0);
      rst_n = 1;
      idle(2);

      send_group(ga, 0);          // R1, R2 back-to-back
      idle(14);
      send_group(gb, 1);          // R1 spaced samples
      idle(14);

      send_row(9, 0, 0);          // R4: ignored before any start
      send_row(9, 1, 0);
      idle(3);
      chk("R4 no readout before start", int'(col_valid), 0);

      pulse_start();
      fill(1, 1);
      send_row(7, 3, 0);          // R4: ignored during readout
      send_row(7, 4, 1);
      idle(2);
      wait_done();
      idle(3);
      chk("R8 done held", int'(done), 1);
      send_row(8, 0, 0);          // R4: ignored after done
      idle(2);
      chk("R8 still done", int'(done), 1);

      pulse_start();
      chk("R9 done cleared", int'(done), 0);
      fill(2, 0);
      idle(40);
      pulse_start();              // R9: restart mid-readout
      chk("R9 col_valid after start", int'(col_valid), 0);
      chk("R9 col_bits after start", int'(col_bits), 0);
      send_row(4, 0, 0);
      send_row(4, 1, 0);          // partial row then restart
      @(negedge clk);
      row_valid = 1; row_bits = 8'h3C;
      pulse_start();
      fill(3, 1);
      wait_done();
      idle(4);
      chk("R8 col_valid low after done", int'(col_valid), 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule